// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt requests and presents them to a processor on two lines: a normal request and a fast request. Each source carries an enable bit, a routing bit that chooses the normal or the fast line, a 4-bit priority, and one word in a 64-entry handler address table. Software turns a source on or off by writing its number to a dedicated set or clear register, so no read-modify-write of an enable mask is ever needed.

For the normal line the controller picks the pending, enabled, unmasked source with the highest priority. It reports that source's number and priority in a status word and drives the source's handler address on a side output, so the processor can branch straight to it. For the fast line it reports only the number of the pending fast source, and software uses that number to index the handler table itself. The request inputs are registered once, and register reads return their data one cycle after the request.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset the control word (0x000) and the mask level (0x004) read 0, every enable bit is clear, every table word reads 0, both status words (0x040, 0x044) read 0xFFFFFFFF, and irq_normal, irq_fast and norm_vector are 0, whatever irq_src holds.
- R2: Writing a value n in 0..63 to 0x008 sets the enable bit of source n, and writing n to 0x00C clears it. No other enable bit changes. A written value of 64 or more changes nothing.
- R3: Bit k of the routing word at 0x010 belongs to source 32+k, and bit k of the word at 0x014 belongs to source k. The value 1 routes the source to the fast line and 0 to the normal line. Both words read back as written.
- R4: The priority of source n is held in the word at 0x020 + 4*(7 - (n>>3)), at bits (n&7)*4+3 down to (n&7)*4.
- R5: The normal status word at 0x040 holds the number of the winning normal source in bits 31:16 and its priority in bits 15:0. The highest priority wins, and among equal priorities the higher source number wins. When no source qualifies the word reads 0xFFFFFFFF. irq_normal is 1 exactly when the word is not 0xFFFFFFFF.
- R6: The mask level at 0x004 holds 5 bits. A normal source whose priority is less than or equal to the mask level cannot win. Any level of 16 or more masks nothing.
- R7: Bit 0 of the control word enables the normal line. While it is 0, irq_normal stays 0 and 0x040 reads 0xFFFFFFFF.
- R8: The fast status word at 0x044 holds the number of the highest-numbered source that is pending, enabled and routed fast, and reads 0xFFFFFFFF when there is none. irq_fast is 1 exactly when such a source exists. Neither depends on control bit 0.
- R9: The table word of source n sits at 0x100 + 4n and reads back as written. norm_vector carries the table word of the normal winner, or 0 when there is no winner.
- R10: irq_src is sampled on each clock edge, and the outputs follow the sampled value. Read data appears on bus_rdata in the cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_src | input | 64 | Level-sensitive source requests |
| irq_normal | output | 1 | Normal interrupt request to the processor |
| irq_fast | output | 1 | Fast interrupt request to the processor |
| norm_vector | output | 32 | Handler address of the normal winner |

## Verification
The case hardest to reach from the ports is a tie between sources with equal priority when the mask level sits right at that priority. To get there, the bench gives source n the priority (5n+3) mod 16, so sources n and n+16 always share a priority. It then steps the mask level through every value from 0 to 17 under fixed request patterns. The priority nibble layout is checked one source at a time: a single nonzero nibble is raised against a background of zeros while every source is requesting, so any misplaced nibble shows up as the wrong winner.

// File: rtl/intvec_pkg.sv
// intvec_pkg: register offsets shared by the controller modules.
// Assumes a 12-bit byte address and word-aligned accesses.
package intvec_pkg;
    localparam int REG_AW = 12;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h000;
    localparam logic [REG_AW-1:0] OFS_MASK  = 12'h004;
    localparam logic [REG_AW-1:0] OFS_ENNUM = 12'h008;
    localparam logic [REG_AW-1:0] OFS_DSNUM = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_TYPE  = 12'h010;
    localparam logic [REG_AW-1:0] OFS_PRIO  = 12'h020;
    localparam logic [REG_AW-1:0] OFS_NSTAT = 12'h040;
    localparam logic [REG_AW-1:0] OFS_FSTAT = 12'h044;
    localparam logic [REG_AW-1:0] OFS_TABLE = 12'h100;
endpackage

// File: rtl/intvec_regs.sv
// intvec_regs: software-visible state of the controller: control bit,
// mask level, enable bits, routing bits, priority words and handler table.
// Assumes NSRC is a multiple of 2*DW and every access is word aligned.
module intvec_regs
    import intvec_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int DW     = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [REG_AW-1:0]                waddr,
    input  logic [DW-1:0]                    wdata,
    output logic                             ctrl_nm,
    output logic [PRIO_W:0]                  mask_lvl,
    output logic [NSRC-1:0]                  en_q,
    output logic [NSRC-1:0]                  ftype_q,
    output logic [NSRC*PRIO_W/DW-1:0][DW-1:0] prio_w,
    output logic [NSRC-1:0][PRIO_W-1:0]      prio_src,
    output logic [NSRC-1:0][DW-1:0]          tbl_q
);
    localparam int IDX_W      = $clog2(NSRC);
    localparam int PRIO_WORDS = NSRC * PRIO_W / DW;
    localparam int NPW        = DW / PRIO_W;
    localparam int PW_IW      = $clog2(PRIO_WORDS);
    localparam int TYPE_WORDS = NSRC / DW;
    localparam int TW_IW      = $clog2(TYPE_WORDS);

    logic aligned;
    logic num_ok;
    logic en_set, en_clr, hit_type, hit_prio, hit_tbl;
    logic [IDX_W-1:0] num;
    logic [TW_IW-1:0] tw_idx;
    logic [PW_IW-1:0] pw_idx;
    logic [IDX_W-1:0] tb_idx;

    // Decode the write address and the source-number operand.
    always_comb begin
        aligned  = (waddr[1:0] == 2'b00);
        num      = wdata[IDX_W-1:0];
        num_ok   = (wdata[DW-1:IDX_W] == '0);
        en_set   = we && (waddr == OFS_ENNUM) && num_ok;
        en_clr   = we && (waddr == OFS_DSNUM) && num_ok;
        hit_type = we && aligned &&
                   (waddr[REG_AW-1:TW_IW+2] == OFS_TYPE[REG_AW-1:TW_IW+2]);
        hit_prio = we && aligned &&
                   (waddr[REG_AW-1:PW_IW+2] == OFS_PRIO[REG_AW-1:PW_IW+2]);
        hit_tbl  = we && aligned &&
                   (waddr[REG_AW-1:IDX_W+2] == OFS_TABLE[REG_AW-1:IDX_W+2]);
        tw_idx   = waddr[TW_IW+1:2];
        pw_idx   = waddr[PW_IW+1:2];
        tb_idx   = waddr[IDX_W+1:2];
    end

    // Hold the control bit and the mask level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_nm  <= 1'b0;
            mask_lvl <= '0;
        end else if (we) begin
            if (waddr == OFS_CTRL) ctrl_nm  <= wdata[0];
            if (waddr == OFS_MASK) mask_lvl <= wdata[PRIO_W:0];
        end
    end

    // Set or clear one enable bit by source number.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (en_set) en_q[num] <= 1'b1;
        else if (en_clr) en_q[num] <= 1'b0;
    end

    // Routing words: the lower-addressed word covers the upper sources.
    always_ff @(posedge clk) begin
        if (!rst_n) ftype_q <= '0;
        else if (hit_type)
            ftype_q[(TYPE_WORDS-1-int'(tw_idx))*DW +: DW] <= wdata;
    end

    // Priority words, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)        prio_w <= '0;
        else if (hit_prio) prio_w[pw_idx] <= wdata;
    end

    // Handler address table, one word per source.
    always_ff @(posedge clk) begin
        if (!rst_n)       tbl_q <= '0;
        else if (hit_tbl) tbl_q[tb_idx] <= wdata;
    end

    // Unpack each source's priority nibble; word order is reversed.
    for (genvar n = 0; n < NSRC; n++) begin : g_prio
        assign prio_src[n] = prio_w[PRIO_WORDS-1-n/NPW][(n%NPW)*PRIO_W +: PRIO_W];
    end

    // R2
    en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set || en_clr) |=> ($countones(en_q ^ $past(en_q)) <= 1));
    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_set || en_clr) |=> $stable(en_q));
endmodule

// File: rtl/intvec_pick.sv
// intvec_pick: chooses one source among candidates, taking the highest
// priority and, among equal priorities, the highest source number.
// Purely combinational; clk and rst_n only clock its checks.
module intvec_pick #(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        found,
    output logic [IDX_W-1:0]            idx,
    output logic [PRIO_W-1:0]           best
);
    // Ascending scan; a later candidate of equal priority takes over.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!found || prio[i] >= best)) begin
                found = 1'b1;
                idx   = i[IDX_W-1:0];
                best  = prio[i];
            end
        end
    end

    // R5
    pick_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[idx]);
    // R5
    pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (cand == '0));
endmodule

// File: rtl/intvec_ctrl.sv
// intvec_ctrl: top of the vectored interrupt controller. Registers the raw
// requests, qualifies them for the normal and fast lines, picks winners,
// drives the request lines and handler address, and serves register reads
// one cycle after the request.
module intvec_ctrl
    import intvec_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 4,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              irq_normal,
    output logic              irq_fast,
    output logic [DW-1:0]     norm_vector
);
    localparam int IDX_W      = $clog2(NSRC);
    localparam int PRIO_WORDS = NSRC * PRIO_W / DW;
    localparam int PW_IW      = $clog2(PRIO_WORDS);
    localparam int TYPE_WORDS = NSRC / DW;
    localparam int TW_IW      = $clog2(TYPE_WORDS);
    localparam int HALF       = DW / 2;

    logic                              ctrl_nm;
    logic [PRIO_W:0]                   mask_lvl;
    logic [NSRC-1:0]                   en_q, ftype_q, req_q;
    logic [PRIO_WORDS-1:0][DW-1:0]     prio_w;
    logic [NSRC-1:0][PRIO_W-1:0]       prio_src;
    logic [NSRC-1:0][PRIO_W-1:0]       zero_prio;
    logic [NSRC-1:0][DW-1:0]           tbl_q;
    logic [NSRC-1:0]                   unmasked, cand_n, cand_f;
    logic                              n_found, f_found;
    logic [IDX_W-1:0]                  n_idx, f_idx;
    logic [PRIO_W-1:0]                 n_best, f_best;
    logic [DW-1:0]                     nstat, fstat, rd_mux;
    logic                              rd_en;
    logic [DW-1:0]                     rdata_q;

    intvec_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_sel && bus_wr),
        .waddr(bus_addr), .wdata(bus_wdata),
        .ctrl_nm(ctrl_nm), .mask_lvl(mask_lvl), .en_q(en_q),
        .ftype_q(ftype_q), .prio_w(prio_w), .prio_src(prio_src),
        .tbl_q(tbl_q)
    );

    // Sample the level requests once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_src;
    end

    // Per-source mask test: levels of 16 and above mask nothing.
    for (genvar n = 0; n < NSRC; n++) begin : g_mask
        assign unmasked[n] = mask_lvl[PRIO_W] || (prio_src[n] > mask_lvl[PRIO_W-1:0]);
    end

    // Qualify candidates for each line.
    always_comb begin
        cand_n    = req_q & en_q & ~ftype_q & unmasked & {NSRC{ctrl_nm}};
        cand_f    = req_q & en_q & ftype_q;
        zero_prio = '0;
    end

    intvec_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_n (
        .clk(clk), .rst_n(rst_n), .cand(cand_n), .prio(prio_src),
        .found(n_found), .idx(n_idx), .best(n_best)
    );

    intvec_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_f (
        .clk(clk), .rst_n(rst_n), .cand(cand_f), .prio(zero_prio),
        .found(f_found), .idx(f_idx), .best(f_best)
    );

    // Build status words, request lines and the normal handler address.
    always_comb begin
        nstat = n_found ? {{(HALF-IDX_W){1'b0}}, n_idx, {(HALF-PRIO_W){1'b0}}, n_best}
                        : '1;
        fstat = f_found ? {{(DW-IDX_W){1'b0}}, f_idx} : '1;
        irq_normal  = n_found;
        irq_fast    = f_found && (f_best == '0);
        norm_vector = n_found ? tbl_q[n_idx] : '0;
    end

    // Select the word addressed by a read.
    always_comb begin
        rd_en  = bus_sel && !bus_wr;
        rd_mux = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr == OFS_CTRL)
                rd_mux = {{(DW-1){1'b0}}, ctrl_nm};
            else if (bus_addr == OFS_MASK)
                rd_mux = {{(DW-PRIO_W-1){1'b0}}, mask_lvl};
            else if (bus_addr == OFS_NSTAT)
                rd_mux = nstat;
            else if (bus_addr == OFS_FSTAT)
                rd_mux = fstat;
            else if (bus_addr[REG_AW-1:TW_IW+2] == OFS_TYPE[REG_AW-1:TW_IW+2])
                rd_mux = ftype_q[(TYPE_WORDS-1-int'(bus_addr[TW_IW+1:2]))*DW +: DW];
            else if (bus_addr[REG_AW-1:PW_IW+2] == OFS_PRIO[REG_AW-1:PW_IW+2])
                rd_mux = prio_w[bus_addr[PW_IW+1:2]];
            else if (bus_addr[REG_AW-1:IDX_W+2] == OFS_TABLE[REG_AW-1:IDX_W+2])
                rd_mux = tbl_q[bus_addr[IDX_W+1:2]];
        end
    end

    // Register read data; hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R7
    nm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_normal |-> ctrl_nm);
    // R8
    fast_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (ftype_q[f_idx] && req_q[f_idx] && en_q[f_idx]));
    // R5
    norm_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_normal |-> (!ftype_q[n_idx] && en_q[n_idx]));
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/sim_intvec_ctrl.sv
// sim_intvec_ctrl: self-checking bench with sweeps over sources, priority
// nibbles, request patterns and mask levels; expected values are computed
// from the requirements.
module sim_intvec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_normal, irq_fast;
    logic [31:0] norm_vector;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [63:0] b_en = '0, b_type = '0;
    logic [3:0]  b_prio [64];
    int          b_mask = 0;
    bit          b_nm = 0;

    always #2 clk = ~clk;

    intvec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_normal(irq_normal), .irq_fast(irq_fast),
        .norm_vector(norm_vector)
    );

    function automatic logic [31:0] tbl_val(int n);
        return 32'hA000_0000 | (n << 12) | ((n * 37) & 32'hFFF);
    endfunction

    function automatic logic [31:0] exp_nstat(logic [63:0] req);
        int bp = -1, bn = -1;
        if (!b_nm) return 32'hFFFF_FFFF;
        for (int i = 63; i >= 0; i--)
            if (req[i] && b_en[i] && !b_type[i] &&
                (b_mask > 15 || int'(b_prio[i]) > b_mask) && int'(b_prio[i]) > bp) begin
                bp = int'(b_prio[i]); bn = i;
            end
        if (bn < 0) return 32'hFFFF_FFFF;
        return (bn << 16) | bp;
    endfunction

    function automatic logic [31:0] exp_fstat(logic [63:0] req);
        for (int i = 63; i >= 0; i--)
            if (req[i] && b_en[i] && b_type[i]) return i;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; bus_sel = 0;
    endtask

    task automatic set_req(logic [63:0] v);
        @(negedge clk);
        irq_src = v;
        @(negedge clk);
    endtask

    task automatic prog_word(int w);
        logic [31:0] d = '0;
        for (int k = 0; k < 8; k++) d[k*4 +: 4] = b_prio[(7 - w) * 8 + k];
        wr(12'h020 + 12'(4 * w), d);
    endtask

    task automatic check_all(string r);
        logic [31:0] v, en, ef;
        en = exp_nstat(irq_src);
        ef = exp_fstat(irq_src);
        check(r, {31'd0, irq_normal}, {31'd0, en != 32'hFFFF_FFFF});
        check(r, norm_vector, (en == 32'hFFFF_FFFF) ? 32'h0 : tbl_val(int'(en[31:16])));
        check(r, {31'd0, irq_fast}, {31'd0, ef != 32'hFFFF_FFFF});
        rd(12'h040, v); check(r, v, en);
        rd(12'h044, v); check(r, v, ef);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] x;
        for (int i = 0; i < 64; i++) b_prio[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(12'h000, v); check("R1", v, 0);
        rd(12'h004, v); check("R1", v, 0);
        rd(12'h114, v); check("R1", v, 0);
        check_all("R1");
        set_req('1);
        check_all("R1");

        // R9: table sweep
        for (int n = 0; n < 64; n++) wr(12'h100 + 12'(4 * n), tbl_val(n));
        for (int n = 0; n < 64; n++) begin
            rd(12'h100 + 12'(4 * n), v); check("R9", v, tbl_val(n));
        end

        // R2: enable and disable each source by number
        wr(12'h000, 1); b_nm = 1;
        wr(12'h004, 32'h1f); b_mask = 31;
        for (int n = 0; n < 64; n++) begin
            wr(12'h008, n); b_en[n] = 1;
            rd(12'h040, v); check("R2", v, n << 16);
            check("R9", norm_vector, tbl_val(n));
            wr(12'h00C, n); b_en[n] = 0;
            rd(12'h040, v); check("R2", v, 32'hFFFF_FFFF);
        end
        wr(12'h008, 64 + 7);
        check_all("R2");
        wr(12'h008, 32'h8000_0003);
        check_all("R2");

        // R4: nibble layout, one source at a time
        for (int n = 0; n < 64; n++) begin wr(12'h008, n); b_en[n] = 1; end
        for (int n = 0; n < 64; n++) begin
            b_prio[n] = 9; prog_word(7 - n / 8);
            rd(12'h040, v); check("R4", v, (n << 16) | 9);
            b_prio[n] = 0; prog_word(7 - n / 8);
        end

        // R5: arbitration under several request patterns
        for (int n = 0; n < 64; n++) b_prio[n] = 4'((n * 5 + 3) % 16);
        for (int w = 0; w < 8; w++) prog_word(w);
        set_req('1);                    check_all("R5");
        set_req(64'h5555_5555_5555_5555); check_all("R5");
        set_req(64'hAAAA_AAAA_AAAA_AAAA); check_all("R5");
        set_req(64'h0001_0000_0000_0001); check_all("R5");
        x = 64'h1234_5678_9ABC_DEF1;
        for (int k = 0; k < 24; k++) begin
            x ^= x << 13; x ^= x >> 7; x ^= x << 17;
            set_req(x); check_all("R5");
        end

        // R6: mask level sweep
        for (int m = 0; m <= 17; m++) begin
            wr(12'h004, m); b_mask = m;
            set_req(64'h0F0F_33CC_F0F0_1248); check_all("R6");
            set_req('1); check_all("R6");
        end
        wr(12'h004, 31); b_mask = 31;

        // R3: routing to the fast line
        wr(12'h010, 32'h0000_0100); wr(12'h014, 32'h0000_0008);
        b_type[40] = 1; b_type[3] = 1;
        set_req(64'd1 << 40); check_all("R3");
        set_req(64'd1 << 3);  check_all("R3");
        set_req((64'd1 << 40) | (64'd1 << 3)); check_all("R8");
        set_req('1); check_all("R3");
        rd(12'h010, v); check("R3", v, 32'h0000_0100);
        rd(12'h014, v); check("R3", v, 32'h0000_0008);

        // R7 and R8: normal line off, fast line unaffected
        wr(12'h000, 0); b_nm = 0;
        check_all("R7");
        check_all("R8");

        // R10: one cycle of request latency and read-data hold
        set_req('0);
        @(negedge clk); irq_src = 64'd1 << 40;
        check("R10", {31'd0, irq_fast}, 0);
        @(negedge clk);
        check("R10", {31'd0, irq_fast}, 1);
        rd(12'h044, v); check("R10", v, 40);
        set_req('0);
        repeat (3) @(negedge clk);
        check("R10", bus_rdata, 40);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule